// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block keeps the per-vector state of a local interrupt controller for one core: a request bit, an in-service bit and a trigger-mode bit for each of 256 vectors, each array held as eight 32-bit words. From a task-priority value and the highest vector in service it forms a processor priority. Pending requests whose priority class does not rise above it are held back. A level interrupt line tells the core that a deliverable request is waiting.

The core takes an interrupt with an acknowledge strobe. The result comes back one cycle later as a kind code and a vector: nothing, the spurious vector, or a real vector that moves from request to in-service. An end-of-interrupt strobe retires the highest vector in service. When that vector was level-triggered, the block sends a one-cycle broadcast pulse carrying the vector, so the interrupt source can re-arm. A control register holds the spurious vector, a software enable and a switch that suppresses the broadcast.

Top module: `vec_irq_ctrl`

## Requirements
- R1: A set strobe marks the request bit of `set_vec_i` and records its trigger mode: level (`set_level_i`=1) or edge. A later set of the same vector overwrites the mode. In the same cycle, `set_fresh_o` is 1 only when that request bit was clear before.
- R2: Among pending requests, the one with the highest vector number is served first.
- R3: The processor priority is the full task-priority value when its class (bits 7:4) is at least the class of the highest in-service vector. Otherwise it is that in-service class followed by four zero bits. An empty in-service set counts as class 0.
- R4: A request is blocked when the processor priority is nonzero and the request's class is less than or equal to the processor-priority class. Acknowledging a blocked request returns kind 1 (spurious) with the low byte of the control register and changes no state. A zero processor priority blocks nothing.
- R5: Acknowledge with no pending request returns kind 0 (none) with vector 0.
- R6: A granted acknowledge returns kind 2 with the vector. It clears that request bit and sets its in-service bit. `ack_vld_o` and the result appear in the cycle after `ack_i`.
- R7: End-of-interrupt clears the highest in-service bit. In the next cycle `eoi_bc_o` pulses with `eoi_vec_o` set to the vector. This happens only if the vector is level-triggered and bit 12 of the control register is 0. Otherwise `eoi_vec_o` stays 0.
- R8: End-of-interrupt with nothing in service changes nothing and gives no pulse.
- R9: The control register resets to 0x0FF. A write keeps bits 12 and 8:0 and drops the rest. Bit 8 is the enable: while it is 0, `irq_o` is low and acknowledge returns kind 0.
- R10: `irq_o` is combinational from the stored state. It is high exactly when the block is enabled and the highest pending request is not blocked.
- R11: Set, acknowledge and end-of-interrupt in one cycle take effect in that order. The acknowledge sees the new request, and the end-of-interrupt sees the vector just placed in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_valid_i | input | 1 | Raise a request |
| set_vec_i | input | 8 | Vector to raise |
| set_level_i | input | 1 | 1 level, 0 edge |
| set_fresh_o | output | 1 | Request bit was clear before this set |
| tpr_we_i | input | 1 | Task-priority write |
| tpr_i | input | 8 | Task-priority value |
| svr_we_i | input | 1 | Control register write |
| svr_i | input | 32 | Control register value |
| ack_i | input | 1 | Acknowledge strobe |
| eoi_i | input | 1 | End-of-interrupt strobe |
| irq_o | output | 1 | Interrupt line to the core |
| ack_vld_o | output | 1 | Acknowledge result valid |
| ack_kind_o | output | 2 | 0 none, 1 spurious, 2 vector |
| ack_vec_o | output | 8 | Acknowledged vector |
| eoi_bc_o | output | 1 | End-of-interrupt broadcast pulse |
| eoi_vec_o | output | 8 | Broadcast vector |

## Verification
The bench targets the equal-class boundary. A pending vector in the same class as the processor priority must return the spurious vector. A design that compares with strict less-than would hand it over. It also checks a task-priority value whose class is 0 and whose low bits are nonzero. Such a value must block class-0 vectors, and a design that tests only the class nibble for zero would let them through. A check on in-service raising the priority exposes a design that uses the task priority alone. Broadcast checks cover edge vectors, the suppression bit and a trigger mode rewritten to level, so a broadcast on the wrong condition or a stale mode shows up as a spurious pulse or a missing one. A cycle with set, acknowledge and end-of-interrupt together exposes any ordering in which the acknowledge misses the new request or the end-of-interrupt misses the vector just placed in service.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int CLS_W = 4;
  typedef enum logic [1:0] {
    ACK_NONE = 2'd0,
    ACK_SPUR = 2'd1,
    ACK_VEC  = 2'd2
  } ack_kind_e;
endpackage

// File: rtl/vic_msb_find.sv
module vic_msb_find #(
  parameter int WORDS  = 8,
  parameter int WORD_W = 32
) (
  input  logic [WORDS*WORD_W-1:0]         bits_i,
  output logic                            any_o,
  output logic [$clog2(WORDS*WORD_W)-1:0] idx_o
);
  localparam int IDX_W = $clog2(WORDS*WORD_W);
  localparam int BIT_W = $clog2(WORD_W);

  logic [WORDS-1:0] w_any;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign w_any[w] = |bits_i[w*WORD_W +: WORD_W];
  end

  // per-word msb, then highest nonzero word
  always_comb begin
    logic [BIT_W-1:0] msb;
    any_o = |w_any;
    idx_o = '0;
    for (int w = 0; w < WORDS; w++) begin
      msb = '0;
      for (int b = 0; b < WORD_W; b++)
        if (bits_i[w*WORD_W + b]) msb = BIT_W'(b);
      if (w_any[w]) idx_o = IDX_W'(w*WORD_W) | IDX_W'(msb);
    end
  end
endmodule

// File: rtl/vic_ppr.sv
module vic_ppr #(
  parameter int VEC_W = 8
) (
  input  logic [VEC_W-1:0] tpr_i,
  input  logic             isr_any_i,
  input  logic [VEC_W-1:0] isr_top_i,
  output logic [VEC_W-1:0] ppr_o
);
  import vic_pkg::*;
  logic [CLS_W-1:0] isr_cls;

  assign isr_cls = isr_any_i ? isr_top_i[VEC_W-1 -: CLS_W] : '0;
  assign ppr_o   = (tpr_i[VEC_W-1 -: CLS_W] >= isr_cls) ? tpr_i
                 : {isr_cls, {(VEC_W-CLS_W){1'b0}}};
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int NUM_VEC = 256,
  parameter int WORD_W  = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        set_valid_i,
  input  logic [7:0]  set_vec_i,
  input  logic        set_level_i,
  output logic        set_fresh_o,
  input  logic        tpr_we_i,
  input  logic [7:0]  tpr_i,
  input  logic        svr_we_i,
  input  logic [31:0] svr_i,
  input  logic        ack_i,
  input  logic        eoi_i,
  output logic        irq_o,
  output logic        ack_vld_o,
  output logic [1:0]  ack_kind_o,
  output logic [7:0]  ack_vec_o,
  output logic        eoi_bc_o,
  output logic [7:0]  eoi_vec_o
);
  import vic_pkg::*;
  localparam int NUM_WORDS = NUM_VEC / WORD_W;
  localparam int VEC_W     = $clog2(NUM_VEC);
  localparam int EN_BIT    = 8;
  localparam int DEOI_BIT  = 12;
  localparam logic [DEOI_BIT:0] SVR_RST = 13'h0FF;

  logic [NUM_VEC-1:0]  irr_q, isr_q, tmr_q;
  logic [VEC_W-1:0]    tpr_q;
  logic [DEOI_BIT:0]   svr_q;
  logic                en;

  logic [NUM_VEC-1:0]  set_mask, ack_mask, eoi_mask, irr_a, tmr_a, isr_b;
  logic                irr_any, isr_any, req_any_a, isr_any_b;
  logic [VEC_W-1:0]    irr_top, isr_top, req_top_a, isr_top_b, ppr;
  logic                blk_now, blk_a, ack_grant, eoi_do, bc_d;
  ack_kind_e           kind_d;
  logic [VEC_W-1:0]    ack_vec_d;

  assign en = svr_q[EN_BIT];

  vic_msb_find #(.WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_irr_find (
    .bits_i(irr_q), .any_o(irr_any), .idx_o(irr_top));
  vic_msb_find #(.WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_isr_find (
    .bits_i(isr_q), .any_o(isr_any), .idx_o(isr_top));
  vic_ppr #(.VEC_W(VEC_W)) u_ppr (
    .tpr_i(tpr_q), .isr_any_i(isr_any), .isr_top_i(isr_top), .ppr_o(ppr));

  // stage 1: request
  assign set_mask    = set_valid_i ? (NUM_VEC'(1) << set_vec_i) : '0;
  assign irr_a       = irr_q | set_mask;
  assign tmr_a       = set_level_i ? (tmr_q | set_mask) : (tmr_q & ~set_mask);
  assign set_fresh_o = set_valid_i & ~irr_q[set_vec_i];
  assign req_any_a   = irr_any | set_valid_i;
  assign req_top_a   = (set_valid_i && (!irr_any || set_vec_i > irr_top)) ? set_vec_i : irr_top;

  assign blk_now = (ppr != '0) && (irr_top[VEC_W-1 -: CLS_W] <= ppr[VEC_W-1 -: CLS_W]);
  assign blk_a   = (ppr != '0) && (req_top_a[VEC_W-1 -: CLS_W] <= ppr[VEC_W-1 -: CLS_W]);
  assign irq_o   = en & irr_any & ~blk_now;

  // stage 2: acknowledge
  always_comb begin
    kind_d    = ACK_NONE;
    ack_vec_d = '0;
    ack_grant = 1'b0;
    if (ack_i && en && req_any_a) begin
      if (blk_a) begin
        kind_d    = ACK_SPUR;
        ack_vec_d = svr_q[VEC_W-1:0];
      end else begin
        kind_d    = ACK_VEC;
        ack_vec_d = req_top_a;
        ack_grant = 1'b1;
      end
    end
  end
  assign ack_mask = ack_grant ? (NUM_VEC'(1) << req_top_a) : '0;

  // stage 3: end of interrupt on in-service set including this cycle's grant
  assign isr_b     = isr_q | ack_mask;
  assign isr_any_b = isr_any | ack_grant;
  assign isr_top_b = (ack_grant && (!isr_any || req_top_a > isr_top)) ? req_top_a : isr_top;
  assign eoi_do    = eoi_i & isr_any_b;
  assign eoi_mask  = eoi_do ? (NUM_VEC'(1) << isr_top_b) : '0;
  assign bc_d      = eoi_do & tmr_a[isr_top_b] & ~svr_q[DEOI_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q      <= '0;
      isr_q      <= '0;
      tmr_q      <= '0;
      tpr_q      <= '0;
      svr_q      <= SVR_RST;
      ack_vld_o  <= 1'b0;
      ack_kind_o <= ACK_NONE;
      ack_vec_o  <= '0;
      eoi_bc_o   <= 1'b0;
      eoi_vec_o  <= '0;
    end else begin
      irr_q      <= irr_a & ~ack_mask;
      isr_q      <= isr_b & ~eoi_mask;
      tmr_q      <= tmr_a;
      if (tpr_we_i) tpr_q <= tpr_i;
      if (svr_we_i) svr_q <= {svr_i[DEOI_BIT], 3'b000, svr_i[EN_BIT:0]};
      ack_vld_o  <= ack_i;
      ack_kind_o <= kind_d;
      ack_vec_o  <= ack_vec_d;
      eoi_bc_o   <= bc_d;
      eoi_vec_o  <= bc_d ? isr_top_b : '0;
    end
  end
endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
  parameter int NUM_VEC = 256
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ack_i,
  input logic               eoi_i,
  input logic               irq_o,
  input logic               ack_vld_o,
  input logic [1:0]         ack_kind_o,
  input logic [7:0]         ack_vec_o,
  input logic               eoi_bc_o,
  input logic [7:0]         eoi_vec_o,
  input logic               svr_en,
  input logic               svr_deoi,
  input logic [NUM_VEC-1:0] irr
);
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !svr_en |-> !irq_o); // R9
  AST_IRQ_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irr != '0)); // R10
  AST_ACK_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> ack_vld_o); // R6
  AST_ACK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |=> (!ack_vld_o && ack_kind_o == 2'd0)); // R6
  AST_NONE_ZERO_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_vld_o && ack_kind_o == 2'd0) |-> (ack_vec_o == 8'd0)); // R5
  AST_BC_AFTER_EOI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_bc_o |-> ($past(eoi_i) && !$past(svr_deoi))); // R7
  AST_BC_VEC_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eoi_bc_o |-> (eoi_vec_o == 8'd0)); // R7
endmodule

bind vec_irq_ctrl vic_checker #(.NUM_VEC(NUM_VEC)) u_vic_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .ack_i(ack_i), .eoi_i(eoi_i),
  .irq_o(irq_o), .ack_vld_o(ack_vld_o), .ack_kind_o(ack_kind_o),
  .ack_vec_o(ack_vec_o), .eoi_bc_o(eoi_bc_o), .eoi_vec_o(eoi_vec_o),
  .svr_en(svr_q[8]), .svr_deoi(svr_q[12]), .irr(irr_q));

// File: tb/vec_irq_ctrl_test.sv
module vec_irq_ctrl_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        set_valid_i = 1'b0, set_level_i = 1'b0;
  logic [7:0]  set_vec_i = '0;
  logic        set_fresh_o;
  logic        tpr_we_i = 1'b0, svr_we_i = 1'b0;
  logic [7:0]  tpr_i = '0;
  logic [31:0] svr_i = '0;
  logic        ack_i = 1'b0, eoi_i = 1'b0;
  logic        irq_o, ack_vld_o, eoi_bc_o;
  logic [1:0]  ack_kind_o;
  logic [7:0]  ack_vec_o, eoi_vec_o;

  int n_cmp = 0;
  int n_bad = 0;

  localparam int K_NONE = 0, K_SPUR = 1, K_VEC = 2;

  always #2.5 clk_i = ~clk_i;

  vec_irq_ctrl uut (.*);

  task automatic check(input string tag, input int unsigned act, input int unsigned exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(posedge clk_i);
    #1 rst_ni = 1'b1;
  endtask

  task automatic wr_svr(input logic [31:0] v);
    svr_we_i = 1'b1; svr_i = v;
    @(posedge clk_i); #1 svr_we_i = 1'b0;
  endtask

  task automatic wr_tpr(input logic [7:0] v);
    tpr_we_i = 1'b1; tpr_i = v;
    @(posedge clk_i); #1 tpr_we_i = 1'b0;
  endtask

  task automatic raise(input logic [7:0] v, input logic lvl, input logic exp_fresh, input string tag);
    set_valid_i = 1'b1; set_vec_i = v; set_level_i = lvl;
    #1 check({tag, " fresh"}, set_fresh_o, exp_fresh);
    @(posedge clk_i); #1 set_valid_i = 1'b0; set_level_i = 1'b0;
  endtask

  task automatic take(input int exp_kind, input logic [7:0] exp_vec, input string tag);
    ack_i = 1'b1;
    @(posedge clk_i); #1 ack_i = 1'b0;
    check({tag, " ack_vld"}, ack_vld_o, 1);
    check({tag, " ack_kind"}, ack_kind_o, exp_kind);
    check({tag, " ack_vec"}, ack_vec_o, exp_vec);
  endtask

  task automatic retire(input logic exp_bc, input logic [7:0] exp_vec, input string tag);
    eoi_i = 1'b1;
    @(posedge clk_i); #1 eoi_i = 1'b0;
    check({tag, " eoi_bc"}, eoi_bc_o, exp_bc);
    check({tag, " eoi_vec"}, eoi_vec_o, exp_bc ? exp_vec : 8'h00);
  endtask

  task automatic irq_is(input logic exp, input string tag);
    #1 check({tag, " irq"}, irq_o, exp);
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R9 reset irq", irq_o, 0);
    check("R6 reset ack_vld", ack_vld_o, 0);
    check("R7 reset eoi_bc", eoi_bc_o, 0);
    take(K_NONE, 8'h00, "R5 empty");
    raise(8'h30, 1'b0, 1'b1, "R1 first");
    irq_is(0, "R9 disabled after reset");
    take(K_NONE, 8'h00, "R9 ack while disabled");
    wr_svr(32'h0000_01FF);
    irq_is(1, "R10 enabled pending");
    take(K_VEC, 8'h30, "R6 grant");
    irq_is(0, "R10 served");
  endtask

  task automatic t_priority();
    do_reset();
    wr_svr(32'h0000_01AB);
    raise(8'h21, 1'b0, 1'b1, "R1 0x21");
    raise(8'h85, 1'b1, 1'b1, "R1 0x85");
    raise(8'h84, 1'b0, 1'b1, "R1 0x84");
    raise(8'h85, 1'b1, 1'b0, "R1 repeat");
    take(K_VEC, 8'h85, "R2 highest");
    irq_is(0, "R4 same class blocked");
    take(K_SPUR, 8'hAB, "R4 spurious");
    retire(1'b1, 8'h85, "R7 level bc");
    irq_is(1, "R10 after eoi");
    take(K_VEC, 8'h84, "R4 state kept");
    retire(1'b0, 8'h00, "R7 edge no bc");
    take(K_VEC, 8'h21, "R2 next");
    retire(1'b0, 8'h00, "R7 edge 0x21");
    take(K_NONE, 8'h00, "R5 drained");
    retire(1'b0, 8'h00, "R8 empty eoi");
    raise(8'h30, 1'b0, 1'b1, "R1 edge 0x30");
    raise(8'h30, 1'b1, 1'b0, "R1 level 0x30");
    take(K_VEC, 8'h30, "R1 take 0x30");
    retire(1'b1, 8'h30, "R1 mode overwritten");
  endtask

  task automatic t_tpr();
    do_reset();
    wr_svr(32'h0000_01FF);
    wr_tpr(8'h50);
    raise(8'h55, 1'b0, 1'b1, "R4 0x55");
    irq_is(0, "R4 tpr blocks equal class");
    take(K_SPUR, 8'hFF, "R4 spurious ff");
    raise(8'h60, 1'b0, 1'b1, "R4 0x60");
    irq_is(1, "R4 higher class");
    take(K_VEC, 8'h60, "R2 0x60");
    raise(8'h65, 1'b0, 1'b1, "R3 0x65");
    irq_is(0, "R3 isr raises ppr");
    wr_tpr(8'h75);
    irq_is(0, "R3 tpr above isr");
    retire(1'b0, 8'h00, "R3 eoi 0x60");
    irq_is(0, "R3 tpr only");
    wr_tpr(8'h05);
    irq_is(1, "R3 low tpr");
    take(K_VEC, 8'h65, "R2 0x65");
    irq_is(0, "R3 isr 0x65 blocks 0x55");
    retire(1'b0, 8'h00, "R7 eoi 0x65");
    irq_is(1, "R10 0x55 free");
    take(K_VEC, 8'h55, "R6 0x55");
    retire(1'b0, 8'h00, "R7 eoi 0x55");
    raise(8'h03, 1'b0, 1'b1, "R3 0x03");
    irq_is(0, "R3 class0 blocked by nonzero ppr");
    wr_tpr(8'h00);
    irq_is(1, "R4 zero ppr never blocks");
    take(K_VEC, 8'h03, "R4 class0 granted");
  endtask

  task automatic t_directed();
    do_reset();
    wr_svr(32'h0000_11FF);
    raise(8'h90, 1'b1, 1'b1, "R7 0x90");
    take(K_VEC, 8'h90, "R7 take 0x90");
    retire(1'b0, 8'h00, "R7 suppressed");
    wr_svr(32'h0000_01FF);
    raise(8'h91, 1'b1, 1'b1, "R7 0x91");
    take(K_VEC, 8'h91, "R7 take 0x91");
    retire(1'b1, 8'h91, "R7 bc restored");
    wr_svr(32'hFFFF_EEFF);
    raise(8'h92, 1'b0, 1'b1, "R9 0x92");
    irq_is(0, "R9 bit8 clear disables");
    take(K_NONE, 8'h00, "R9 disabled ack");
    wr_svr(32'hFFFF_E1C7);
    irq_is(1, "R9 re-enabled");
    raise(8'h93, 1'b1, 1'b1, "R9 0x93");
    take(K_VEC, 8'h93, "R9 take 0x93");
    take(K_SPUR, 8'hC7, "R9 spurious low byte");
    retire(1'b1, 8'h93, "R9 bit12 from write");
  endtask

  task automatic t_same_cycle();
    do_reset();
    wr_svr(32'h0000_01FF);
    raise(8'h40, 1'b0, 1'b1, "R11 0x40");
    set_valid_i = 1'b1; set_vec_i = 8'h70; set_level_i = 1'b1;
    ack_i = 1'b1; eoi_i = 1'b1;
    @(posedge clk_i); #1;
    set_valid_i = 1'b0; set_level_i = 1'b0; ack_i = 1'b0; eoi_i = 1'b0;
    check("R11 ack kind", ack_kind_o, K_VEC);
    check("R11 ack vec", ack_vec_o, 8'h70);
    check("R11 bc", eoi_bc_o, 1);
    check("R11 bc vec", eoi_vec_o, 8'h70);
    irq_is(1, "R11 0x40 left");
    take(K_VEC, 8'h40, "R11 take 0x40");
    retire(1'b0, 8'h00, "R11 eoi 0x40");
    take(K_NONE, 8'h00, "R11 all clear");
  endtask

  initial begin
    t_reset_state();
    t_priority();
    t_tpr();
    t_directed();
    t_same_cycle();
    summary();
    $finish;
  end
endmodule